// File: doc/BRIEF.md
# Transceiver Status and Soft Control Register

This block holds one byte of an optical transceiver's management space. The byte mirrors the module's discrete pins: TX disable, the two rate-select inputs, TX fault and receive loss of signal. It also carries two bits that software may write to override the hardware controls, and an active-low flag that reports when measurement data is ready. Pin inputs pass through a two-flop synchronizer. The mirror bits are refreshed on a prescaled tick whose period sits well inside the 100 ms bound the pins allow.

The effective laser-disable output is the synchronized TX-disable pin ORed with the soft disable bit. The effective full-bandwidth output is the synchronized rate-select-0 pin ORed with the soft rate bit. Each soft control can be left out by a parameter. A soft control that is left out reads back as 0 and has no effect on the outputs. The host writes the byte through a single-cycle write strobe, and the current value is always present on the read port.

Top module: `xcvr_stat_ctl`

## Requirements
- R1: Status byte layout: bit 7 = TX-disable pin mirror, bit 5 = rate-select-1 pin mirror, bit 4 = rate-select-0 pin mirror, bit 2 = TX-fault mirror, bit 1 = receive-LOS mirror.
- R2: Mirror bits change only on a refresh tick, which occurs every TICK_DIV cycles. A pin level held steady appears in the byte within TICK_DIV+3 cycles.
- R3: Bit 6 is the soft TX disable. It is written from wr_data_i[6] when wr_en_i is high, and it resets to 0. laser_off_o = synchronized TX-disable pin OR bit 6.
- R4: Bit 3 is the soft rate select. It is written from wr_data_i[3] when wr_en_i is high, and it resets to 0. rate_full_o = synchronized rate-select-0 pin OR bit 3.
- R5: When a soft control is disabled by its parameter, its bit reads 0 and writing 1 to it leaves laser_off_o and rate_full_o equal to the pin levels alone.
- R6: Bit 0 is 1 from reset. It goes to 0 on the clock edge after data_valid_i is first seen high, and it stays 0 until reset.
- R7: Host writes do not change bits 7, 5, 4, 2, 1 and 0.
- R8: laser_off_o and rate_full_o follow their pins two clock edges after a change, independent of the refresh tick.
- R9: After reset the byte reads 8'h01, and both effective outputs follow only the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| txdis_pin_i | input | 1 | Hard TX-disable pin (asynchronous) |
| rs0_pin_i | input | 1 | Rate-select-0 pin (asynchronous) |
| rs1_pin_i | input | 1 | Rate-select-1 pin (asynchronous) |
| txfault_i | input | 1 | TX-fault indicator (asynchronous) |
| rxlos_i | input | 1 | Receive loss-of-signal indicator (asynchronous) |
| data_valid_i | input | 1 | Measurement data valid (synchronous) |
| wr_en_i | input | 1 | Host write strobe for this byte |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Assembled status byte |
| laser_off_o | output | 1 | Effective laser disable |
| rate_full_o | output | 1 | Effective full-bandwidth select |

## Verification
The bench drives all 32 combinations of the five pins. For each one it checks that every mirror bit lands on its own position, which separates a swapped or shifted field from a correct one. Every pin pattern is crossed with all four soft-bit settings, so the OR terms can be told apart from a plain pass-through or an AND. The bench changes the pins just after a refresh and checks that the byte holds, which shows whether the mirror waits for the tick or copies the synchronizer directly. A second instance built with both soft controls disabled receives all-ones writes, which shows whether the read-only and unimplemented bits are really masked.

// File: rtl/xcvr_stat_pkg.sv
package xcvr_stat_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned B_TXDIS   = 7;
  localparam int unsigned B_SOFTDIS = 6;
  localparam int unsigned B_RS1     = 5;
  localparam int unsigned B_RS0     = 4;
  localparam int unsigned B_SOFTRS  = 3;
  localparam int unsigned B_FAULT   = 2;
  localparam int unsigned B_LOS     = 1;
  localparam int unsigned B_NRDY    = 0;
  localparam int unsigned NUM_PINS  = 5;

  typedef struct packed {
    logic txdis;
    logic rs1;
    logic rs0;
    logic fault;
    logic los;
  } pin_vec_t;
endpackage

// File: rtl/xcvr_pin_sync.sv
module xcvr_pin_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xcvr_tick_gen.sv
module xcvr_tick_gen #(
  parameter int unsigned TICK_DIV = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(TICK_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R2: a refresh is never followed by another on the next cycle
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (TICK_DIV < 2) || !tick_o);
endmodule

// File: rtl/xcvr_soft_bit.sv
module xcvr_soft_bit #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  output logic soft_o
);
  if (IMPL) begin : g_impl
    logic soft_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) soft_q <= 1'b0;
      else if (wr_en_i) soft_q <= wr_bit_i;
    end
    assign soft_o = soft_q;

    // R3/R4: soft bit only moves on a host write
    a_r3_soft_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> $stable(soft_q));
  end else begin : g_none
    logic unused_wr;
    assign unused_wr = wr_en_i ^ wr_bit_i;
    assign soft_o = 1'b0;
  end
endmodule

// File: rtl/xcvr_stat_ctl.sv
module xcvr_stat_ctl
  import xcvr_stat_pkg::*;
#(
  parameter int unsigned TICK_DIV      = 1_000_000,
  parameter bit          SOFT_DIS_IMPL = 1'b1,
  parameter bit          SOFT_RS_IMPL  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              txdis_pin_i,
  input  logic              rs0_pin_i,
  input  logic              rs1_pin_i,
  input  logic              txfault_i,
  input  logic              rxlos_i,
  input  logic              data_valid_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              laser_off_o,
  output logic              rate_full_o
);
  pin_vec_t pins_raw, pins_s, mirror_q;
  logic     tick, soft_dis, soft_rs, nrdy_q;
  logic     unused_ro;

  assign pins_raw = '{txdis: txdis_pin_i, rs1: rs1_pin_i, rs0: rs0_pin_i,
                      fault: txfault_i, los: rxlos_i};

  xcvr_pin_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_raw), .q_o(pins_s)
  );

  xcvr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  xcvr_soft_bit #(.IMPL(SOFT_DIS_IMPL)) u_soft_dis (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_bit_i(wr_data_i[B_SOFTDIS]), .soft_o(soft_dis)
  );

  xcvr_soft_bit #(.IMPL(SOFT_RS_IMPL)) u_soft_rs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_bit_i(wr_data_i[B_SOFTRS]), .soft_o(soft_rs)
  );

  assign unused_ro = ^{wr_data_i[B_TXDIS], wr_data_i[B_RS1], wr_data_i[B_RS0],
                       wr_data_i[B_FAULT], wr_data_i[B_LOS], wr_data_i[B_NRDY]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mirror_q <= '0;
    else if (tick) mirror_q <= pins_s;
  end

  // active-low ready: sticky low once data is valid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nrdy_q <= 1'b1;
    else if (data_valid_i) nrdy_q <= 1'b0;
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[B_TXDIS]   = mirror_q.txdis;
    rd_data_o[B_SOFTDIS] = soft_dis;
    rd_data_o[B_RS1]     = mirror_q.rs1;
    rd_data_o[B_RS0]     = mirror_q.rs0;
    rd_data_o[B_SOFTRS]  = soft_rs;
    rd_data_o[B_FAULT]   = mirror_q.fault;
    rd_data_o[B_LOS]     = mirror_q.los;
    rd_data_o[B_NRDY]    = nrdy_q;
  end

  assign laser_off_o = pins_s.txdis | soft_dis;
  assign rate_full_o = pins_s.rs0 | soft_rs;

  // R2: mirror only moves on a refresh tick
  a_r2_mirror_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(mirror_q));

  // R6: ready flag never returns high once low
  a_r6_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[B_NRDY] |=> !rd_data_o[B_NRDY]);

  // R3: pin or soft bit disables the laser
  a_r3_laser_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_SOFTDIS] || pins_s.txdis) |-> laser_off_o);

  // R4: full bandwidth needs the pin or the soft bit
  a_r4_rate_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_full_o |-> (rd_data_o[B_SOFTRS] || pins_s.rs0));

  // R5: disabled soft controls read back zero
  a_r5_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SOFT_DIS_IMPL || !rd_data_o[B_SOFTDIS]) && (SOFT_RS_IMPL || !rd_data_o[B_SOFTRS]));
endmodule

// File: tb/xcvr_stat_ctl_tb.sv
module xcvr_stat_ctl_tb;
  localparam int unsigned DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pins = '0;  // {txdis, rs1, rs0, fault, los}
  logic       dv = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rd_a, rd_b;
  logic       off_a, rate_a, off_b, rate_b;
  int         total = 0, bad = 0;
  bit         exp_nrdy = 1'b1;

  always #2 clk = ~clk;

  xcvr_stat_ctl #(.TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .txdis_pin_i(pins[4]), .rs0_pin_i(pins[2]),
    .rs1_pin_i(pins[3]), .txfault_i(pins[1]), .rxlos_i(pins[0]),
    .data_valid_i(dv), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd_a), .laser_off_o(off_a), .rate_full_o(rate_a)
  );

  xcvr_stat_ctl #(.TICK_DIV(DIV), .SOFT_DIS_IMPL(1'b0), .SOFT_RS_IMPL(1'b0)) u_dut_min (
    .clk_i(clk), .rst_ni(rst_n), .txdis_pin_i(pins[4]), .rs0_pin_i(pins[2]),
    .rs1_pin_i(pins[3]), .txfault_i(pins[1]), .rxlos_i(pins[0]),
    .data_valid_i(dv), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd_b), .laser_off_o(off_b), .rate_full_o(rate_b)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mir(input logic [4:0] p);
    return {p[4], 1'b0, p[3], p[2], 1'b0, p[1], p[0], 1'b0};
  endfunction

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wd = d;
    @(negedge clk); we = 1'b0; wd = '0;
  endtask

  task automatic wait_mirror(input logic [4:0] p, input string req);
    logic [7:0] want;
    bit hit = 0;
    want = mir(p);
    for (int i = 0; i < DIV + 4 && !hit; i++) begin
      @(negedge clk);
      if ((rd_a & 8'hB6) == want) hit = 1;
    end
    chk(req, rd_a & 8'hB6, want);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 rd", rd_a, 8'h01);
    chk("R9 rd min", rd_b, 8'h01);
    chk("R9 outs", {6'b0, off_a, rate_a}, 8'h00);
    rst_n = 1'b1;

    // R1/R2: every pin pattern lands in its own bit
    for (int p = 0; p < 32; p++) begin
      @(negedge clk); pins = 5'(p);
      wait_mirror(5'(p), "R1 mirror");
      chk("R6 nrdy high", {7'b0, rd_a[0]}, 8'h01);
    end

    // R2: mirror holds between ticks
    pins = 5'b00000;
    wait_mirror(5'b00000, "R2 settle");
    @(negedge clk); pins = 5'b11111;
    repeat (3) @(negedge clk);
    chk("R2 hold", rd_a & 8'hB6, 8'h00);
    wait_mirror(5'b11111, "R2 refresh");

    // R3/R4/R8: pin x soft sweep
    for (int s = 0; s < 4; s++) begin
      host_wr({1'b0, s[1], 2'b0, s[0], 3'b0});
      chk("R3 R4 readback", rd_a & 8'h48, {1'b0, s[1], 2'b0, s[0], 3'b0});
      for (int p = 0; p < 32; p++) begin
        @(negedge clk); pins = 5'(p);
        @(negedge clk); @(negedge clk);
        chk("R8 R3 laser", {7'b0, off_a}, {7'b0, pins[4] | s[1]});
        chk("R8 R4 rate", {7'b0, rate_a}, {7'b0, pins[2] | s[0]});
        chk("R5 min outs", {6'b0, off_b, rate_b}, {6'b0, pins[4], pins[2]});
      end
    end

    // R7/R5: all-ones write
    @(negedge clk); pins = '0;
    wait_mirror(5'b00000, "R7 settle");
    repeat (DIV + 2) @(negedge clk);
    host_wr(8'hFF);
    chk("R7 ro ignored", rd_a, 8'h49);
    chk("R5 min read", rd_b, 8'h01);
    chk("R5 min outs", {6'b0, off_b, rate_b}, 8'h00);
    host_wr(8'h00);
    chk("R7 clear soft", rd_a, 8'h01);

    // R6: ready flag
    @(negedge clk); dv = 1'b1;
    @(negedge clk); dv = 1'b0; exp_nrdy = 1'b0;
    chk("R6 nrdy low", {7'b0, rd_a[0]}, {7'b0, exp_nrdy});
    host_wr(8'hFF);
    repeat (20) @(negedge clk);
    chk("R6 sticky", {7'b0, rd_a[0]}, 8'h00);
    chk("R6 min sticky", rd_b, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule